// File: doc/BRIEF.md
# Vector Branch Condition Reducer

This unit decides whether a conditional branch applied across a vector of condition bits is taken. After a start pulse it captures a 5-bit branch control field, the per-element condition bits, a predicate mask, a 64-bit loop count, a width mode and a set of reduction and truncation mode bits. It then visits one element per clock. For each element it tests the loop count, tests the element's condition bit, and may decrement the count. It folds each element's result into a single taken/not-taken answer.

Evaluation can stop before the last element. This happens when one element already settles the answer. It also happens when the truncation feature trims the vector length at the first element whose combined result matches a chosen value. At the end the unit pulses done. It then presents the decision, the updated count and the possibly shortened vector length, and holds them until the next accepted start. The unit does not compute branch targets or fetch instructions.

Top module: `vbc_eval_top`

## Requirements
- R1: While and after reset, `done`, `busy`, `taken`, `ctr_out` and `vl_out` are all zero.
- R2: A `start` seen while idle captures every input. A `start` seen while busy is ignored. `done` is high for exactly one cycle, N cycles after the capturing edge, where N is the number of elements visited. `taken`, `ctr_out` and `vl_out` then hold until the next accepted start.
- R3: The count is "nonzero" when its low 32 bits are nonzero with `wide_mode`=0, or when all 64 bits are nonzero with `wide_mode`=1.
- R4: The counter check of an element is `bctl[2] | (nonzero ^ bctl[1])`. It uses the count as it stands before that element's decrement.
- R5: The element check is `bctl[4] | ~(test_bit ^ bctl[3])`. `bctl[0]` has no effect.
- R6: With `bctl[2]`=0, the count drops by one per element. The exception is when `inv_test_en`=1 and (element check XOR `inv_test_pol`)=1: then the count is left unchanged for that element.
- R7: Consider an element whose `pred_mask` bit is 0. If `bctl[2]`=0, `inv_test_en`=1 and `inv_test_pol`=0, the count drops by one and the element is skipped with no other effect. Otherwise its test bit is `masked_val` instead of its `cond_vec` bit.
- R8: The combined result of an element is (element check AND counter check). The running decision starts at 1 when `and_reduce`=1 and at 0 when `and_reduce`=0. Each combined result is ANDed into it or ORed into it, according to `and_reduce`.
- R9: With `trunc_en`=1, the first non-skipped element i whose combined result equals `trunc_match` ends the run. `vl_out` becomes i+1 when `trunc_incl`=1, or i when `trunc_incl`=0.
- R10: A run also ends at any non-skipped element whose combined result differs from `and_reduce`. Otherwise it ends after element VL-1.
- R11: With `vl_in`=0, `done` pulses the cycle after the capturing edge. `taken` equals `and_reduce`, and the count and VL are returned unchanged.
- R12: A `vl_in` above MAXVL (8) is treated as MAXVL, and that clamped value is reported on `vl_out` unless truncated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run, capturing all inputs |
| bctl | input | 5 | Branch control field |
| cond_vec | input | MAXVL | Per-element condition bits |
| pred_mask | input | MAXVL | Per-element predicate mask |
| ctr_in | input | 64 | Initial loop count |
| wide_mode | input | 1 | 1: 64-bit count test, 0: 32-bit |
| and_reduce | input | 1 | 1: AND reduction, 0: OR reduction |
| masked_val | input | 1 | Test bit used for masked-out elements |
| trunc_en | input | 1 | Enable vector length truncation |
| trunc_match | input | 1 | Combined result value that triggers truncation |
| trunc_incl | input | 1 | Include the matching element in the new length |
| inv_test_en | input | 1 | Enable decrement suppression on inverted test |
| inv_test_pol | input | 1 | Polarity of the inverted test |
| vl_in | input | VLW | Vector length |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Final branch decision |
| ctr_out | output | 64 | Updated count |
| vl_out | output | VLW | Updated vector length |

## Verification
Several pattern families are applied, and each one separates a different aspect of the behaviour.
- Condition patterns with a single set bit, under OR reduction, separate first-match early exit from a full-length scan.
- All-ones patterns and patterns with one hole, under AND reduction, separate a complete pass from a mid-vector stop.
- Counts such as 3, 2^32 and 2^32+2 separate the 32-bit and 64-bit nonzero tests, and show that each check uses the count before that element's decrement.
- Partial predicate masks, combined with each inverted-test setting, separate the skip-with-decrement path from the substitute-test-bit path.
- Truncation is tried with both match values and both inclusion settings, next to zero and oversized lengths and randomly drawn mixes.
- Done latency is compared against the visited element count on every run.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

    localparam int CTR_W = 64;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } vbc_state_e;

    // decoded branch control field
    typedef struct packed {
        logic ign_cond;
        logic want_cond;
        logic ign_ctr;
        logic ctr_pol;
    } bctl_t;

    // reduction, truncation and inverted-test mode bits
    typedef struct packed {
        logic and_reduce;
        logic masked_val;
        logic trunc_en;
        logic trunc_match;
        logic trunc_incl;
        logic inv_en;
        logic inv_pol;
    } vmode_t;

    // per-element evaluation result
    typedef struct packed {
        logic skip;
        logic comb;
        logic dec;
    } elem_res_t;

    function automatic bctl_t decode_bctl(input logic [4:0] f);
        bctl_t b;
        b.ign_cond  = f[4];
        b.want_cond = f[3];
        b.ign_ctr   = f[2];
        b.ctr_pol   = f[1];
        return b;
    endfunction

endpackage

// File: rtl/vbc_counter.sv
module vbc_counter
    import vbc_pkg::*;
#(
    parameter int CW = CTR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] ld_val,
    input  logic          ld_wide,
    input  logic          dec,
    output logic [CW-1:0] ctr_q,
    output logic          nz
);
    localparam int HALF = CW / 2;

    logic wide_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctr_q  <= '0;
            wide_q <= 1'b0;
        end else if (load) begin
            ctr_q  <= ld_val;
            wide_q <= ld_wide;
        end else if (dec) begin
            ctr_q  <= ctr_q - CW'(1);
        end
    end

    assign nz = wide_q ? (|ctr_q) : (|ctr_q[HALF-1:0]);

    AST_CTR_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        !load |=> (ctr_q == $past(ctr_q)) || (ctr_q == $past(ctr_q) - CW'(1))); // R6

    AST_CTR_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> ctr_q == $past(ld_val)); // R2

endmodule

// File: rtl/vbc_elem.sv
module vbc_elem
    import vbc_pkg::*;
(
    input  bctl_t     bc,
    input  vmode_t    md,
    input  logic      ctr_nz,
    input  logic      mask_bit,
    input  logic      cond_bit,
    output elem_res_t res
);
    logic ctr_ok;
    logic test_bit;
    logic el_ok;
    logic suppress;

    always_comb begin
        ctr_ok   = bc.ign_ctr | (ctr_nz ^ bc.ctr_pol);
        res.skip = !mask_bit && !bc.ign_ctr && md.inv_en && !md.inv_pol;
        test_bit = mask_bit ? cond_bit : md.masked_val;
        el_ok    = bc.ign_cond | ~(test_bit ^ bc.want_cond);
        suppress = md.inv_en && (el_ok ^ md.inv_pol);
        res.dec  = res.skip | (!bc.ign_ctr && !suppress);
        res.comb = el_ok & ctr_ok;
    end

endmodule

// File: rtl/vbc_seq.sv
module vbc_seq
    import vbc_pkg::*;
#(
    parameter int MAXVL = 8,
    parameter int VLW   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VLW-1:0]   vl_in,
    input  logic [MAXVL-1:0] cond_in,
    input  logic [MAXVL-1:0] mask_in,
    input  bctl_t            bctl_in,
    input  vmode_t           mode_in,
    input  elem_res_t        res,
    output logic             load,
    output bctl_t            bctl_q,
    output vmode_t           mode_q,
    output logic             cur_cond,
    output logic             cur_mask,
    output logic             dec_en,
    output logic             done,
    output logic             busy,
    output logic             taken,
    output logic [VLW-1:0]   vl_q
);
    localparam logic [VLW-1:0] VL_CAP = VLW'(MAXVL);

    vbc_state_e       st_q;
    logic [VLW-1:0]   idx_q;
    logic             acc_q;
    logic [MAXVL-1:0] cond_q;
    logic [MAXVL-1:0] mask_q;

    logic             running;
    logic             last;
    logic             hit_trunc;
    logic             early;
    logic             stop;
    logic             acc_n;
    logic [VLW-1:0]   trunc_vl;
    logic [VLW-1:0]   vl_clamped;

    // element select
    always_comb begin
        cur_cond = 1'b0;
        cur_mask = 1'b0;
        for (int i = 0; i < MAXVL; i++) begin
            if (idx_q == VLW'(i)) begin
                cur_cond = cond_q[i];
                cur_mask = mask_q[i];
            end
        end
    end

    always_comb begin
        running    = (st_q == ST_RUN);
        load       = start && (st_q == ST_IDLE);
        dec_en     = running && res.dec;
        last       = (idx_q == vl_q - VLW'(1));
        hit_trunc  = !res.skip && mode_q.trunc_en && (res.comb == mode_q.trunc_match);
        early      = !res.skip && (mode_q.and_reduce != res.comb);
        stop       = last || hit_trunc || early;
        trunc_vl   = mode_q.trunc_incl ? (idx_q + VLW'(1)) : idx_q;
        vl_clamped = (vl_in > VL_CAP) ? VL_CAP : vl_in;
        if (res.skip)
            acc_n = acc_q;
        else if (mode_q.and_reduce)
            acc_n = acc_q & res.comb;
        else
            acc_n = acc_q | res.comb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            acc_q  <= 1'b0;
            vl_q   <= '0;
            cond_q <= '0;
            mask_q <= '0;
            bctl_q <= '0;
            mode_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        cond_q <= cond_in;
                        mask_q <= mask_in;
                        bctl_q <= bctl_in;
                        mode_q <= mode_in;
                        idx_q  <= '0;
                        acc_q  <= mode_in.and_reduce;
                        vl_q   <= vl_clamped;
                        st_q   <= (vl_in == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    acc_q <= acc_n;
                    if (hit_trunc)
                        vl_q <= trunc_vl;
                    if (stop)
                        st_q <= ST_FIN;
                    else
                        idx_q <= idx_q + VLW'(1);
                end
                ST_FIN: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign done  = (st_q == ST_FIN);
    assign busy  = (st_q != ST_IDLE);
    assign taken = acc_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R2

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !start) |=> ($stable(acc_q) && $stable(vl_q))); // R2

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        running |-> (idx_q < vl_q) && (vl_q <= VL_CAP)); // R12

    AST_VL_NEVER_GROWS: assert property (@(posedge clk) disable iff (rst)
        running |=> vl_q <= $past(vl_q)); // R9

    AST_ZERO_VL_DONE: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && start && vl_in == '0) |=> done); // R11

    AST_AND_FAIL_STOPS: assert property (@(posedge clk) disable iff (rst)
        (running && mode_q.and_reduce && !res.skip && !res.comb) |=> (done && !taken)); // R10

endmodule

// File: rtl/vbc_eval_top.sv
module vbc_eval_top
    import vbc_pkg::*;
#(
    parameter int MAXVL = 8,
    localparam int VLW  = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [4:0]       bctl,
    input  logic [MAXVL-1:0] cond_vec,
    input  logic [MAXVL-1:0] pred_mask,
    input  logic [63:0]      ctr_in,
    input  logic             wide_mode,
    input  logic             and_reduce,
    input  logic             masked_val,
    input  logic             trunc_en,
    input  logic             trunc_match,
    input  logic             trunc_incl,
    input  logic             inv_test_en,
    input  logic             inv_test_pol,
    input  logic [VLW-1:0]   vl_in,
    output logic             busy,
    output logic             done,
    output logic             taken,
    output logic [63:0]      ctr_out,
    output logic [VLW-1:0]   vl_out
);
    bctl_t     bctl_d;
    bctl_t     bctl_q;
    vmode_t    mode_d;
    vmode_t    mode_q;
    elem_res_t res;
    logic      load;
    logic      dec_en;
    logic      cur_cond;
    logic      cur_mask;
    logic      ctr_nz;

    always_comb begin
        bctl_d             = decode_bctl(bctl);
        mode_d.and_reduce  = and_reduce;
        mode_d.masked_val  = masked_val;
        mode_d.trunc_en    = trunc_en;
        mode_d.trunc_match = trunc_match;
        mode_d.trunc_incl  = trunc_incl;
        mode_d.inv_en      = inv_test_en;
        mode_d.inv_pol     = inv_test_pol;
    end

    vbc_seq #(.MAXVL(MAXVL), .VLW(VLW)) seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .vl_in    (vl_in),
        .cond_in  (cond_vec),
        .mask_in  (pred_mask),
        .bctl_in  (bctl_d),
        .mode_in  (mode_d),
        .res      (res),
        .load     (load),
        .bctl_q   (bctl_q),
        .mode_q   (mode_q),
        .cur_cond (cur_cond),
        .cur_mask (cur_mask),
        .dec_en   (dec_en),
        .done     (done),
        .busy     (busy),
        .taken    (taken),
        .vl_q     (vl_out)
    );

    vbc_counter #(.CW(CTR_W)) ctr_i (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .ld_val  (ctr_in),
        .ld_wide (wide_mode),
        .dec     (dec_en),
        .ctr_q   (ctr_out),
        .nz      (ctr_nz)
    );

    vbc_elem elem_i (
        .bc       (bctl_q),
        .md       (mode_q),
        .ctr_nz   (ctr_nz),
        .mask_bit (cur_mask),
        .cond_bit (cur_cond),
        .res      (res)
    );

endmodule

// File: tb/vbc_eval_top_tb_top.sv
module vbc_eval_top_tb_top;
    localparam int MAXVL = 8;
    localparam int VLW   = 4;

    // mode vector layout: {and_reduce, masked_val, trunc_en, trunc_match, trunc_incl, inv_en, inv_pol}
    localparam logic [6:0] M_OR  = 7'b0000000;
    localparam logic [6:0] M_AND = 7'b1000000;

    typedef struct {
        string       req;
        logic        taken;
        logic [63:0] ctr;
        logic [3:0]  vl;
        int          n;
        int          due;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [4:0]       bctl = '0;
    logic [MAXVL-1:0] cond_vec = '0;
    logic [MAXVL-1:0] pred_mask = '0;
    logic [63:0]      ctr_in = '0;
    logic             wide_mode = 1'b0;
    logic [6:0]       md = '0;
    logic [VLW-1:0]   vl_in = '0;
    logic             busy, done, taken;
    logic [63:0]      ctr_out;
    logic [VLW-1:0]   vl_out;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];
    exp_t last_exp;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vbc_eval_top #(.MAXVL(MAXVL)) dut_i (
        .clk(clk), .rst(rst), .start(start), .bctl(bctl),
        .cond_vec(cond_vec), .pred_mask(pred_mask), .ctr_in(ctr_in),
        .wide_mode(wide_mode), .and_reduce(md[6]), .masked_val(md[5]),
        .trunc_en(md[4]), .trunc_match(md[3]), .trunc_incl(md[2]),
        .inv_test_en(md[1]), .inv_test_pol(md[0]), .vl_in(vl_in),
        .busy(busy), .done(done), .taken(taken), .ctr_out(ctr_out), .vl_out(vl_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // reference from the requirements
    function automatic exp_t model(input logic [4:0] b, input logic [7:0] cv, input logic [7:0] pm,
                                   input logic [63:0] c, input logic m64, input logic [6:0] m,
                                   input logic [3:0] vli);
        exp_t e;
        logic acc, nz, cok, tb, eok, cmb;
        int   vl;
        e.req = "";
        e.due = 0;
        vl  = (vli > 4'(MAXVL)) ? MAXVL : int'(vli);
        acc = m[6];
        e.n = 0;
        for (int i = 0; i < vl; i++) begin
            e.n++;
            nz  = m64 ? (c != 0) : (c[31:0] != 0);
            cok = b[2] | (nz ^ b[1]);
            if (!pm[i] && !b[2] && m[1] && !m[0]) begin
                c = c - 1;
                continue;
            end
            tb  = pm[i] ? cv[i] : m[5];
            eok = b[4] | ~(tb ^ b[3]);
            if (!b[2] && !(m[1] && (eok ^ m[0]))) c = c - 1;
            cmb = eok & cok;
            acc = m[6] ? (acc & cmb) : (acc | cmb);
            if (m[4] && (cmb == m[3])) begin
                vl = m[2] ? i + 1 : i;
                break;
            end
            if (m[6] != cmb) break;
        end
        e.taken = acc;
        e.ctr   = c;
        e.vl    = 4'(vl);
        return e;
    endfunction

    // driver: push expected item, pulse start, wait for the monitor to retire it
    task automatic run_case(input string req, input logic [4:0] b, input logic [7:0] cv,
                            input logic [7:0] pm, input logic [63:0] c, input logic m64,
                            input logic [6:0] m, input logic [3:0] vli, input bit inject);
        exp_t e;
        e = model(b, cv, pm, c, m64, m, vli);
        e.req = req;
        @(negedge clk);
        bctl = b; cond_vec = cv; pred_mask = pm; ctr_in = c;
        wide_mode = m64; md = m; vl_in = vli; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        e.due = cyc + e.n;
        sb_q.push_back(e);
        last_exp = e;
        if (inject) begin
            @(negedge clk);
            // R2: start while busy must be ignored
            bctl = 5'b10100; cond_vec = '0; ctr_in = 64'd77; md = M_OR;
            vl_in = 4'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2: actual unexpected done expected none");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check({e.req, " taken"}, 64'(taken), 64'(e.taken));
                check({e.req, " ctr"}, ctr_out, e.ctr);
                check({e.req, " vl"}, 64'(vl_out), 64'(e.vl));
                check("R2 done latency", 64'(cyc), 64'(e.due));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", 64'(done), 0);
        check("R1 busy", 64'(busy), 0);
        check("R1 taken", 64'(taken), 0);
        check("R1 ctr", ctr_out, 0);
        check("R1 vl", 64'(vl_out), 0);
        rst = 1'b0;
        @(negedge clk);

        // R5 R8 R10: OR reduce, first match exits
        run_case("R5 or-first-match", 5'b01100, 8'b0001_0000, 8'hFF, 64'd9, 1'b1, M_OR, 4'd8, 1'b0);
        run_case("R5 want-zero", 5'b00100, 8'b1111_1011, 8'hFF, 64'd9, 1'b1, M_OR, 4'd8, 1'b0);
        run_case("R5 bit0-no-effect", 5'b01101, 8'b0001_0000, 8'hFF, 64'd9, 1'b1, M_OR, 4'd8, 1'b0);
        run_case("R8 or-no-match", 5'b01100, 8'h00, 8'hFF, 64'd9, 1'b1, M_OR, 4'd8, 1'b0);
        run_case("R8 and-all-pass", 5'b01100, 8'hFF, 8'hFF, 64'd9, 1'b1, M_AND, 4'd8, 1'b0);
        run_case("R10 and-hole", 5'b01100, 8'hFB, 8'hFF, 64'd9, 1'b1, M_AND, 4'd8, 1'b0);
        run_case("R5 ignore-cond", 5'b10100, 8'h00, 8'hFF, 64'd9, 1'b1, M_AND, 4'd6, 1'b0);
        // R4 R6: counter check before decrement
        run_case("R4 count-down", 5'b10000, 8'h00, 8'hFF, 64'd3, 1'b1, M_AND, 4'd8, 1'b0);
        run_case("R4 zero-pol", 5'b10010, 8'h00, 8'hFF, 64'd0, 1'b1, M_AND, 4'd5, 1'b0);
        // R3 width of nonzero test
        run_case("R3 narrow-zero", 5'b10000, 8'h00, 8'hFF, 64'h1_0000_0000, 1'b0, M_AND, 4'd4, 1'b0);
        run_case("R3 wide-nonzero", 5'b10000, 8'h00, 8'hFF, 64'h1_0000_0000, 1'b1, M_AND, 4'd4, 1'b0);
        run_case("R3 narrow-wrap", 5'b10000, 8'h00, 8'hFF, 64'h1_0000_0002, 1'b0, M_AND, 4'd8, 1'b0);
        // R6 suppression of decrement on inverted test
        run_case("R6 suppress-pol1", 5'b01000, 8'b1010_1111, 8'hFF, 64'd20, 1'b1, 7'b0000010 | 7'b0000001, 4'd8, 1'b0);
        run_case("R6 suppress-pol0", 5'b01000, 8'b0000_0000, 8'hFF, 64'd20, 1'b1, 7'b0000010, 4'd8, 1'b0);
        // R7 masked-out handling
        run_case("R7 skip-dec", 5'b01000, 8'h00, 8'b0101_0101, 64'd20, 1'b1, 7'b0000010, 4'd8, 1'b0);
        run_case("R7 masked-val1", 5'b01100, 8'h00, 8'b0000_0011, 64'd20, 1'b1, 7'b0100000, 4'd8, 1'b0);
        run_case("R7 masked-val0", 5'b01100, 8'hFF, 8'b1111_0000, 64'd20, 1'b1, 7'b1000000, 4'd8, 1'b0);
        // R9 truncation
        run_case("R9 trunc-incl", 5'b01100, 8'b0000_0100, 8'hFF, 64'd5, 1'b1, 7'b0011100, 4'd8, 1'b0);
        run_case("R9 trunc-excl", 5'b01100, 8'b0000_0100, 8'hFF, 64'd5, 1'b1, 7'b0011000, 4'd8, 1'b0);
        run_case("R9 trunc-match0", 5'b01100, 8'b1110_1111, 8'hFF, 64'd5, 1'b1, 7'b1010100, 4'd8, 1'b0);
        run_case("R9 trunc-at-0", 5'b01100, 8'b0000_0001, 8'hFF, 64'd5, 1'b1, 7'b0011000, 4'd8, 1'b0);
        // R11 R12
        run_case("R11 zero-vl", 5'b00000, 8'hFF, 8'hFF, 64'd42, 1'b1, M_AND, 4'd0, 1'b0);
        run_case("R11 zero-vl-or", 5'b00000, 8'hFF, 8'hFF, 64'd42, 1'b1, M_OR, 4'd0, 1'b0);
        run_case("R12 clamp", 5'b01100, 8'hFF, 8'hFF, 64'd9, 1'b1, M_AND, 4'd13, 1'b0);
        // R2 start while busy ignored, then outputs hold
        run_case("R2 busy-ignore", 5'b01100, 8'hFF, 8'hFF, 64'd100, 1'b1, M_AND, 4'd8, 1'b1);
        repeat (5) @(negedge clk);
        check("R2 hold taken", 64'(taken), 64'(last_exp.taken));
        check("R2 hold ctr", ctr_out, last_exp.ctr);
        check("R2 hold vl", 64'(vl_out), 64'(last_exp.vl));
        check("R2 idle busy", 64'(busy), 0);

        // mixed random cases
        for (int k = 0; k < 40; k++) begin
            logic [63:0] rc;
            rc = ($urandom_range(0, 3) == 0) ? {32'($urandom_range(0, 1)), 32'($urandom_range(0, 4))}
                                              : 64'($urandom_range(0, 9));
            run_case("R8 random-mix", 5'($urandom_range(0, 31)), 8'($urandom_range(0, 255)),
                     8'($urandom_range(0, 255)), rc, 1'($urandom_range(0, 1)),
                     7'($urandom_range(0, 127)), 4'($urandom_range(0, 10)), 1'b0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule